// File: doc/BRIEF.md
# Next Program Counter Unit

This block chooses the program counter for the next instruction of a 32-bit RISC core and holds the current PC in a register. Each cycle it receives a decoded flow class (sequential, branch-if-equal, branch-if-not-equal, direct jump, direct jump with link, register jump), the 16-bit branch displacement, the 26-bit jump word field, the two compared operands and a register target value. From these it forms the next PC, a taken flag, a request to write the return address into register 31 and an alignment error for a misaligned register target.

The PC register loads a parameterised start address on synchronous reset. After that it takes the computed next PC on every rising clock edge. The next-PC output is combinational from the current PC and the decode inputs.

Top module: `npc_unit`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) loads START_ADDR into pc. The default START_ADDR is 32'h0040_0000.
- R2: Flow class SEQ (code 3'd0) gives next_pc = pc+4 and taken = 0.
- R3: Class BEQ (3'd1) is taken when op_a == op_b. Class BNE (3'd2) is taken when op_a != op_b. When taken, next_pc = pc+4 + (sign-extended br_off << 2).
- R4: A branch whose condition fails gives next_pc = pc+4 and taken = 0.
- R5: Classes JMP (3'd3) and JAL (3'd4) give next_pc = {pc+4 bits[31:28], jmp_idx, 2'b00} and taken = 1.
- R6: Class JAL asserts link_we with link_addr = pc+4. link_we is 0 for every other class.
- R7: Class JREG (3'd5) gives next_pc = reg_tgt and taken = 1.
- R8: Class JREG with reg_tgt[1:0] != 0 raises misalign. misalign is 0 for every other class and for aligned targets.
- R9: At each rising edge without reset, pc takes the value that next_pc had before the edge. Class codes 6 and 7 behave as SEQ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flow | input | 3 | Decoded flow class |
| br_off | input | 16 | Branch word displacement |
| jmp_idx | input | 26 | Jump word field |
| op_a | input | 32 | First compared operand |
| op_b | input | 32 | Second compared operand |
| reg_tgt | input | 32 | Register jump target |
| pc | output | 32 | Current PC |
| next_pc | output | 32 | Computed next PC |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Write return address to register 31 |
| link_addr | output | 32 | Return address value |
| misalign | output | 1 | Register target not word aligned |

## Verification
Two functions can fall in the same cycle. A JAL produces both a redirect and a link write, and both values come from one shared pc+4. The bench checks next_pc and link_addr against independently computed values in that same cycle. The bench also issues a JREG to a misaligned address and checks two things together: the transfer still goes to the raw target, and misalign is raised. A further check sets pc near a 256 MB region boundary, so that the upper bits of pc+4 differ from those of pc, and confirms that the jump region comes from pc+4.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  flow,
  input  logic [15:0] br_off,
  input  logic [25:0] jmp_idx,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [31:0] reg_tgt,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        taken,
  output logic        link_we,
  output logic [31:0] link_addr,
  output logic        misalign
);
  localparam logic [2:0] SEQ = 3'd0, BEQ = 3'd1, BNE = 3'd2,
                         JMP = 3'd3, JAL = 3'd4, JREG = 3'd5;

  logic [31:0] seq_pc, br_pc, jmp_pc;
  logic        eq;

  assign seq_pc = pc + 32'd4;
  assign br_pc  = seq_pc + {{14{br_off[15]}}, br_off, 2'b00};
  assign jmp_pc = {seq_pc[31:28], jmp_idx, 2'b00};
  assign eq     = (op_a == op_b);

  always_comb begin
    next_pc = seq_pc;
    taken   = 1'b0;
    unique case (flow)
      BEQ:  if (eq)  begin next_pc = br_pc;   taken = 1'b1; end
      BNE:  if (!eq) begin next_pc = br_pc;   taken = 1'b1; end
      JMP, JAL:      begin next_pc = jmp_pc;  taken = 1'b1; end
      JREG:          begin next_pc = reg_tgt; taken = 1'b1; end
      default: ;
    endcase
  end

  assign link_we   = (flow == JAL);
  assign link_addr = seq_pc;
  assign misalign  = (flow == JREG) && (reg_tgt[1:0] != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) pc <= START_ADDR;
    else     pc <= next_pc;
  end

  a_r9_pc_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pc == $past(next_pc)));
  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> (pc == START_ADDR));
  a_r4_not_taken_seq: assert property (@(posedge clk) disable iff (rst)
    !taken |-> (next_pc == pc + 32'd4));
  a_r6_link_is_jump: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (taken && next_pc[31:28] == link_addr[31:28]));
  a_r8_misalign_taken: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (taken && next_pc[1:0] != 2'b00));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] START = 32'h0040_0000;

  logic clk = 0, rst = 1;
  logic [2:0] flow = 0;
  logic [15:0] br_off = 0;
  logic [25:0] jmp_idx = 0;
  logic [31:0] op_a = 0, op_b = 0, reg_tgt = 0;
  logic [31:0] pc, next_pc, link_addr;
  logic taken, link_we, misalign;
  int n_chk = 0, n_fail = 0;

  npc_unit #(.START_ADDR(START)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // flow, br_off, jmp_idx, op_a, op_b, reg_tgt
  typedef struct packed {
    logic [2:0] f; logic [15:0] bo; logic [25:0] ji;
    logic [31:0] a, b, rt;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{3'd0, 16'h0000, 26'h0, 32'd0, 32'd0, 32'd0},
    '{3'd1, 16'h0010, 26'h0, 32'd5, 32'd5, 32'd0},
    '{3'd1, 16'h0010, 26'h0, 32'd5, 32'd6, 32'd0},
    '{3'd2, 16'hFFFC, 26'h0, 32'd1, 32'd2, 32'd0},
    '{3'd2, 16'h0004, 26'h0, 32'd9, 32'd9, 32'd0},
    '{3'd3, 16'h0000, 26'h0123456, 32'd0, 32'd0, 32'd0},
    '{3'd4, 16'h0000, 26'h0040100, 32'd0, 32'd0, 32'd0},
    '{3'd5, 16'h0000, 26'h0, 32'd0, 32'd0, 32'h0040_2000},
    '{3'd6, 16'h0008, 26'h3FFFFFF, 32'd1, 32'd1, 32'd3},
    '{3'd5, 16'h0000, 26'h0, 32'd0, 32'd0, 32'h0040_3002}
  };

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // Independent model of the next-PC choice
  task automatic model(input logic [31:0] p, output logic [31:0] np,
                       output logic tk, output logic lw, output logic ma);
    logic [31:0] s;
    s = p + 4; np = s; tk = 0; lw = 0; ma = 0;
    case (flow)
      3'd1: if (op_a == op_b) begin np = s + {{14{br_off[15]}}, br_off, 2'b00}; tk = 1; end
      3'd2: if (op_a != op_b) begin np = s + {{14{br_off[15]}}, br_off, 2'b00}; tk = 1; end
      3'd3: begin np = {s[31:28], jmp_idx, 2'b00}; tk = 1; end
      3'd4: begin np = {s[31:28], jmp_idx, 2'b00}; tk = 1; lw = 1; end
      3'd5: begin np = reg_tgt; tk = 1; ma = (reg_tgt[1:0] != 0); end
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD*1000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] exp_pc, np; logic tk, lw, ma;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset pc", pc, START);
    rst = 0;
    exp_pc = START;
    for (int i = 0; i < NV; i++) begin
      flow = VT[i].f; br_off = VT[i].bo; jmp_idx = VT[i].ji;
      op_a = VT[i].a; op_b = VT[i].b; reg_tgt = VT[i].rt;
      #1;
      model(exp_pc, np, tk, lw, ma);
      chk("R2/R3/R4/R5/R7 next_pc", next_pc, np);
      chk("R2/R3/R4/R5/R7 taken", {31'd0, taken}, {31'd0, tk});
      chk("R6 link_we", {31'd0, link_we}, {31'd0, lw});
      chk("R6 link_addr", link_addr, exp_pc + 4);
      chk("R8 misalign", {31'd0, misalign}, {31'd0, ma});
      @(posedge clk); #1;
      exp_pc = np;
      chk("R9 pc update", pc, exp_pc);
    end
    // R5 region from pc+4: jump from region boundary
    flow = 3'd5; reg_tgt = 32'h1FFF_FFFC; @(posedge clk); #1;
    flow = 3'd4; jmp_idx = 26'h0000010; #1;
    chk("R5 region from pc+4", next_pc, 32'h2000_0040);
    chk("R6 link at boundary", link_addr, 32'h2000_0000);
    chk("R6 link_we jal", {31'd0, link_we}, 32'd1);
    // R3 negative offset branch
    flow = 3'd1; op_a = 7; op_b = 7; br_off = 16'h8000; #1;
    chk("R3 most negative offset", next_pc, 32'h2000_0000 - 32'h0002_0000);
    // R8 other class with misaligned reg_tgt
    flow = 3'd0; reg_tgt = 32'h3; #1;
    chk("R8 no misalign on SEQ", {31'd0, misalign}, 32'd0);
    // R1 reset mid-run
    rst = 1; @(posedge clk); #1;
    chk("R1 reset again", pc, START);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule